// File: doc/BRIEF.md
# USB Device Token Busy-Guard

This block sits between the token decoder of a full-speed USB device and its endpoint response logic. When an isochronous OUT transaction ends, endpoint status still has to be written back in the system clock domain, and an isochronous transaction has no handshake phase to cover that work. The host may therefore send the next token almost at once. The guard opens a busy window of a parameterised number of PHY clocks when it is told that an isochronous OUT has ended. The window closes early when the status write-back reports that it is done.

A token that arrives while the window is closed is passed on unchanged to the normal response logic. A token that arrives while the window is open gets a safe response, chosen by token and transfer type:

- Bulk, interrupt and control data tokens are answered with a NAK request.
- A SETUP token is dropped without a trace, and the host recovers by retrying after its timeout.
- An isochronous token is dropped, and the drop raises an incomplete-transfer event for its direction.

All outputs are registered and appear one clock after the token.

Top module: `usb_tkn_guard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every output is 0 and the window is closed. A token presented right after reset is forwarded.
- R2: A pulse on `iso_out_end` in cycle N opens the window for cycles N+1 through N+WIN_LEN; the default WIN_LEN is 7. A token in cycle N itself, or in cycle N+WIN_LEN+1 or later, is not guarded.
- R3: An unguarded token in cycle N gives `fwd_valid`=1 in cycle N+1, with `fwd_kind` and `fwd_xfer` equal to the token's kind and transfer type. `nak_req` and `drop_stb` stay 0. When `fwd_valid` is 0, `fwd_kind` and `fwd_xfer` are 0.
- R4: A guarded IN (`tok_kind`=1) or OUT (`tok_kind`=2) token is answered with `nak_req`=1 one cycle later, and nothing is forwarded. This applies when the transfer type is control (`tok_xfer`=0), bulk (2) or interrupt (3).
- R5: A guarded SETUP token (`tok_kind`=3) gives `drop_stb`=1 one cycle later, with both incomplete-event outputs at 0. This holds for any transfer type.
- R6: A guarded isochronous (`tok_xfer`=1) IN token gives `drop_stb`=1 and `iso_in_miss`=1 one cycle later.
- R7: A guarded isochronous OUT token gives `drop_stb`=1 and `iso_out_miss`=1 one cycle later.
- R8: A pulse on `stat_upd_done` while the window is open closes the window from the next cycle on. A token in the same cycle as that pulse is still guarded. The pulse has no effect while the window is closed.
- R9: A pulse on `iso_out_end` while the window is open restarts the full window. If `iso_out_end` and `stat_upd_done` arrive in the same cycle, `iso_out_end` wins.
- R10: In any cycle at most one of `fwd_valid`, `nak_req` and `drop_stb` is 1. No output is 1 in a cycle that follows a cycle without `tok_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | A decoded token is present this cycle |
| tok_kind | input | 2 | Token kind: 1 IN, 2 OUT, 3 SETUP |
| tok_xfer | input | 2 | Endpoint transfer type: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| iso_out_end | input | 1 | Pulse: an isochronous OUT transaction has just ended |
| stat_upd_done | input | 1 | Pulse: endpoint status write-back has finished |
| fwd_valid | output | 1 | Token forwarded to normal response logic |
| fwd_kind | output | 2 | Kind of the forwarded token |
| fwd_xfer | output | 2 | Transfer type of the forwarded token |
| nak_req | output | 1 | Request a NAK handshake for the guarded token |
| drop_stb | output | 1 | Guarded token dropped with no response |
| iso_in_miss | output | 1 | Event: an isochronous IN token was dropped |
| iso_out_miss | output | 1 | Event: an isochronous OUT token was dropped |

## Verification
The assertions check on every cycle the properties that depend on the current and previous cycle only:

- At most one response is given, and only after a real token.
- Forwarded fields copy the token.
- An incomplete-event pulse always comes with a drop, and a dropped SETUP raises no event.
- The window counter stays in range, and it reloads or clears as commanded.

Only the bench scenarios can show where the window starts and ends in time relative to the `iso_out_end` pulse. The same holds for the early close through `stat_upd_done`, the restart on a second isochronous OUT, and the response chosen for each combination of token and transfer type.

// File: rtl/tkn_guard_pkg.sv
package tkn_guard_pkg;

   // Token kinds as delivered by the token decoder
   typedef enum logic [1:0] {
      TK_NONE  = 2'd0,
      TK_IN    = 2'd1,
      TK_OUT   = 2'd2,
      TK_SETUP = 2'd3
   } tok_kind_e;

   // Endpoint transfer types
   typedef enum logic [1:0] {
      XF_CTRL = 2'd0,
      XF_ISO  = 2'd1,
      XF_BULK = 2'd2,
      XF_INTR = 2'd3
   } xfer_e;

   // Response decision for one token
   typedef struct packed {
      logic fwd;
      logic nak;
      logic drop;
      logic in_miss;
      logic out_miss;
   } resp_t;

   localparam resp_t RESP_NONE = '{fwd: 1'b0, nak: 1'b0, drop: 1'b0,
                                   in_miss: 1'b0, out_miss: 1'b0};

endpackage

// File: rtl/tkn_guard_window.sv
// Busy-window timer: reloads on the end of an isochronous OUT and counts
// down in PHY clocks; optionally cleared early by the status-done pulse.
module tkn_guard_window #(
   parameter int unsigned WIN_LEN     = 7,
   parameter bit          EARLY_CLOSE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reopen,
   input  logic upd_done,
   output logic open
);

   localparam int unsigned CNT_W = $clog2(WIN_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_LEN);

   if (WIN_LEN < 1) begin : g_bad_len
      $error("tkn_guard_window: WIN_LEN must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             early_clr;

   // Parameter picks whether the status-done pulse can shorten the window
   if (EARLY_CLOSE) begin : g_early
      assign early_clr = upd_done;
   end else begin : g_fixed
      assign early_clr = 1'b0;
   end

   always_comb begin
      cnt_d = cnt_q;
      if (reopen) begin
         cnt_d = CNT_LOAD;
      end else if (early_clr) begin
         cnt_d = '0;
      end else if (cnt_q != '0) begin
         cnt_d = cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign open = (cnt_q != '0);

   // R2: the countdown never leaves its legal range
   assert_win_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LOAD);

   // R9: a new isochronous OUT end always restarts the full window
   assert_reopen_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reopen |=> (cnt_q == CNT_LOAD));

   // R8: early close takes effect on the next cycle
   if (EARLY_CLOSE) begin : g_early_chk
      assert_early_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (upd_done && !reopen) |=> !open);
   end

endmodule

// File: rtl/tkn_guard_classify.sv
// Chooses the response for one token from its kind, transfer type and
// whether the busy window is open.
module tkn_guard_classify
   import tkn_guard_pkg::*;
(
   input  logic       tok_valid,
   input  logic [1:0] tok_kind,
   input  logic [1:0] tok_xfer,
   input  logic       guard,
   output resp_t      resp
);

   logic is_setup;
   logic is_iso;
   logic is_in;

   assign is_setup = (tok_kind == TK_SETUP);
   assign is_iso   = (tok_xfer == XF_ISO);
   assign is_in    = (tok_kind == TK_IN);

   always_comb begin
      resp = RESP_NONE;
      if (tok_valid) begin
         if (!guard) begin
            resp.fwd = 1'b1;
         end else if (is_setup) begin
            // silent drop: host retries after its timeout
            resp.drop = 1'b1;
         end else if (is_iso) begin
            resp.drop     = 1'b1;
            resp.in_miss  = is_in;
            resp.out_miss = !is_in;
         end else begin
            // control data, bulk and interrupt: handshake-capable
            resp.nak = 1'b1;
         end
      end
   end

endmodule

// File: rtl/usb_tkn_guard.sv
module usb_tkn_guard
   import tkn_guard_pkg::*;
#(
   parameter int unsigned WIN_LEN     = 7,
   parameter bit          EARLY_CLOSE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tok_valid,
   input  logic [1:0] tok_kind,
   input  logic [1:0] tok_xfer,
   input  logic       iso_out_end,
   input  logic       stat_upd_done,
   output logic       fwd_valid,
   output logic [1:0] fwd_kind,
   output logic [1:0] fwd_xfer,
   output logic       nak_req,
   output logic       drop_stb,
   output logic       iso_in_miss,
   output logic       iso_out_miss
);

   logic  win_open;
   resp_t resp;

   tkn_guard_window #(
      .WIN_LEN     (WIN_LEN),
      .EARLY_CLOSE (EARLY_CLOSE)
   ) i_window (
      .clk      (clk),
      .rst_n    (rst_n),
      .reopen   (iso_out_end),
      .upd_done (stat_upd_done),
      .open     (win_open)
   );

   tkn_guard_classify i_classify (
      .tok_valid (tok_valid),
      .tok_kind  (tok_kind),
      .tok_xfer  (tok_xfer),
      .guard     (win_open),
      .resp      (resp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid    <= 1'b0;
         fwd_kind     <= '0;
         fwd_xfer     <= '0;
         nak_req      <= 1'b0;
         drop_stb     <= 1'b0;
         iso_in_miss  <= 1'b0;
         iso_out_miss <= 1'b0;
      end else begin
         fwd_valid    <= resp.fwd;
         fwd_kind     <= resp.fwd ? tok_kind : 2'd0;
         fwd_xfer     <= resp.fwd ? tok_xfer : 2'd0;
         nak_req      <= resp.nak;
         drop_stb     <= resp.drop;
         iso_in_miss  <= resp.in_miss;
         iso_out_miss <= resp.out_miss;
      end
   end

   // R10: at most one response kind per cycle
   assert_one_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fwd_valid, nak_req, drop_stb}));

   // R10: a response only follows a real token
   assert_resp_needs_tok_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_valid |=> !(fwd_valid || nak_req || drop_stb || iso_in_miss || iso_out_miss));

   // R3: forwarded fields copy the token of the previous cycle
   assert_fwd_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid |=> (!fwd_valid || (fwd_kind == $past(tok_kind) && fwd_xfer == $past(tok_xfer))));

   // R6 / R7: incomplete events ride on a drop, one direction at a time
   assert_miss_with_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (iso_in_miss || iso_out_miss) |-> (drop_stb && !(iso_in_miss && iso_out_miss)));

   // R5: a SETUP token never raises an incomplete event
   assert_setup_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_kind == TK_SETUP) |=> !(iso_in_miss || iso_out_miss));

endmodule

// File: tb/test_usb_tkn_guard.sv
module test_usb_tkn_guard;

   localparam int unsigned W = 7;

   // expected response codes
   localparam logic [2:0] E_FWD = 3'd0, E_NAK = 3'd1, E_DROP = 3'd2,
                          E_DIN = 3'd3, E_DOUT = 3'd4;

   typedef struct packed {
      logic [7:0] gap;   // cycles from iso_out_end to token
      logic [1:0] kind;
      logic [1:0] xf;
      logic [2:0] exp;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{8'd1,  2'd2, 2'd2, E_NAK},
      '{8'd3,  2'd1, 2'd3, E_NAK},
      '{8'd7,  2'd1, 2'd2, E_NAK},
      '{8'd8,  2'd1, 2'd2, E_FWD},
      '{8'd0,  2'd2, 2'd1, E_FWD},
      '{8'd2,  2'd3, 2'd0, E_DROP},
      '{8'd4,  2'd3, 2'd2, E_DROP},
      '{8'd5,  2'd1, 2'd1, E_DIN},
      '{8'd6,  2'd2, 2'd1, E_DOUT},
      '{8'd1,  2'd2, 2'd0, E_NAK},
      '{8'd9,  2'd3, 2'd0, E_FWD},
      '{8'd20, 2'd2, 2'd1, E_FWD},
      '{8'd7,  2'd1, 2'd1, E_DIN},
      '{8'd1,  2'd2, 2'd1, E_DOUT}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tok_valid = 1'b0;
   logic [1:0] tok_kind = '0;
   logic [1:0] tok_xfer = '0;
   logic       iso_out_end = 1'b0;
   logic       stat_upd_done = 1'b0;
   logic       fwd_valid, nak_req, drop_stb, iso_in_miss, iso_out_miss;
   logic [1:0] fwd_kind, fwd_xfer;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   usb_tkn_guard #(.WIN_LEN(W)) i_usb_tkn_guard (
      .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
      .tok_xfer(tok_xfer), .iso_out_end(iso_out_end), .stat_upd_done(stat_upd_done),
      .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_xfer(fwd_xfer),
      .nak_req(nak_req), .drop_stb(drop_stb), .iso_in_miss(iso_in_miss),
      .iso_out_miss(iso_out_miss)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic clear_in();
      tok_valid = 1'b0; tok_kind = '0; tok_xfer = '0;
      iso_out_end = 1'b0; stat_upd_done = 1'b0;
   endtask

   task automatic set_tok(input logic [1:0] k, input logic [1:0] x);
      tok_valid = 1'b1; tok_kind = k; tok_xfer = x;
   endtask

   // check outputs against expected code; kind/xfer for forwarding
   task automatic check(input logic [2:0] e, input logic [1:0] k,
                        input logic [1:0] x, input string req);
      logic [7:0] act, expv;
      act  = {fwd_valid, fwd_kind, fwd_xfer, nak_req, drop_stb, iso_in_miss};
      expv = {e == E_FWD, (e == E_FWD) ? k : 2'd0, (e == E_FWD) ? x : 2'd0,
              e == E_NAK, e == E_DROP || e == E_DIN || e == E_DOUT, e == E_DIN};
      total++;
      if (act != expv || iso_out_miss != (e == E_DOUT)) begin
         bad++;
         $display("FAIL %s: actual outs=%b out_miss=%b expected outs=%b out_miss=%b",
                  req, act, iso_out_miss, expv, e == E_DOUT);
      end
   endtask

   task automatic check_idle(input string req);
      total++;
      if ({fwd_valid, fwd_kind, fwd_xfer, nak_req, drop_stb, iso_in_miss, iso_out_miss} != '0) begin
         bad++;
         $display("FAIL %s: actual outs=%b expected all zero", req,
                  {fwd_valid, fwd_kind, fwd_xfer, nak_req, drop_stb, iso_in_miss, iso_out_miss});
      end
   endtask

   function automatic string tag_of(input logic [2:0] e, input logic [7:0] g);
      if (e == E_FWD)  return (g == 0 || g > W) ? "R2" : "R3";
      if (e == E_NAK)  return "R4";
      if (e == E_DROP) return "R5";
      if (e == E_DIN)  return "R6";
      return "R7";
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      clear_in();
      iso_out_end = 1'b1;
      set_tok(2'd2, 2'd2);
      repeat (3) tick();
      check_idle("R1 during reset");
      clear_in();
      rst_n = 1'b1;
      tick();
      check_idle("R1 after reset");
      set_tok(2'd1, 2'd1);
      tick(); clear_in();
      check(E_FWD, 2'd1, 2'd1, "R1 token after reset forwarded");

      // table walk
      for (int i = 0; i < NV; i++) begin
         iso_out_end = 1'b1;
         if (VEC[i].gap == 0) set_tok(VEC[i].kind, VEC[i].xf);
         tick(); clear_in();
         if (VEC[i].gap != 0) begin
            repeat (int'(VEC[i].gap) - 1) tick();
            set_tok(VEC[i].kind, VEC[i].xf);
            tick(); clear_in();
         end
         check(VEC[i].exp, VEC[i].kind, VEC[i].xf, tag_of(VEC[i].exp, VEC[i].gap));
         repeat (W + 2) tick();
      end

      // R10: no token inside an open window gives no output
      iso_out_end = 1'b1;
      tick(); clear_in();
      tick();
      check_idle("R10 idle cycle in open window");
      repeat (W + 2) tick();

      // R8: early close; token with the done pulse is still guarded
      iso_out_end = 1'b1;
      tick(); clear_in();
      tick();
      set_tok(2'd2, 2'd2); stat_upd_done = 1'b1;
      tick(); clear_in();
      check(E_NAK, 2'd2, 2'd2, "R8 token with done pulse guarded");
      set_tok(2'd2, 2'd2);
      tick(); clear_in();
      check(E_FWD, 2'd2, 2'd2, "R8 window closed after done pulse");
      // R8: done pulse while closed has no effect on later window
      repeat (W + 2) tick();
      stat_upd_done = 1'b1;
      tick(); clear_in();
      iso_out_end = 1'b1;
      tick(); clear_in();
      repeat (W - 1) tick();
      set_tok(2'd1, 2'd3);
      tick(); clear_in();
      check(E_NAK, 2'd1, 2'd3, "R8 stale done pulse ignored");
      repeat (W + 2) tick();

      // R9: restart while open
      iso_out_end = 1'b1;
      tick(); clear_in();
      repeat (3) tick();
      iso_out_end = 1'b1;
      tick(); clear_in();
      repeat (W - 1) tick();
      set_tok(2'd1, 2'd2);
      tick(); clear_in();
      check(E_NAK, 2'd1, 2'd2, "R9 restarted window still open");
      set_tok(2'd1, 2'd2);
      tick(); clear_in();
      check(E_FWD, 2'd1, 2'd2, "R9 restarted window closed");
      repeat (W + 2) tick();

      // R9: reopen beats done in same cycle
      iso_out_end = 1'b1; stat_upd_done = 1'b1;
      tick(); clear_in();
      set_tok(2'd2, 2'd1);
      tick(); clear_in();
      check(E_DOUT, 2'd2, 2'd1, "R9 reopen wins over done");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule